// File: doc/BRIEF.md
# Context Wait Tracker and Scheduler

This block decides which of the loaded hardware contexts owns the pipeline in each cycle and keeps one waiting flag per context. When the running context issues a memory operation that cannot finish, the pipeline is told not to advance for that context. Its waiting flag is raised, and on the next cycle another ready context takes over. The switch costs no cycles, because every context's pipeline state stays in place.

The memory system reports that a pending operation can now finish by pulsing a response strobe and placing a context number on a context bus that it shares with the processor. The processor asserts an early claim on that bus in cycles where it needs it, and a response offered in a claimed cycle is not taken. A response that is taken clears the named context's waiting flag. That context runs on the very next cycle and replays its pending operation.

When no response is taken, contexts flagged as running a trap handler are served before ordinary contexts. A ready running context keeps the pipeline. Otherwise the search goes round-robin, starting after the running context. If every context is waiting, the block reports idle and holds its state until a response arrives.

Top module: `ctx_sched`

## Requirements
- R1: After synchronous reset the running context is 0, the idle output is low and every waiting flag is clear.
- R2: When `mem_block_i` is high while the block is not idle, `advance_o` is low in that cycle and the running context's waiting flag is set from the next cycle, unless a response taken in the same cycle names that context.
- R3: When the block is not idle and `mem_block_i` is low, `advance_o` is high. While idle, `advance_o` is low.
- R4: When the running context blocks and no response or trap context intervenes, the next running context is the first ready one found after it in increasing index order, wrapping from N-1 to 0.
- R5: A response is taken (`rsp_take_o` high) only when `rsp_valid_i` is high and `bus_claim_i` is low. A response offered in a claimed cycle changes neither the flags nor the running context.
- R6: A taken response clears the waiting flag of the context on `rsp_ctx_i`, whether or not that context was waiting. That context runs in the next cycle. A block by the same context in the same cycle loses to the response.
- R7: A context whose waiting flag is set is never the running context while the block is not idle.
- R8: Responses taken on consecutive cycles are each honoured: each one switches the pipeline to its own context in the cycle that follows it.
- R9: When no response is taken and some ready context has its bit set in `trap_act_i`, the next running context is one of those trap contexts. The running context is kept if it qualifies; otherwise the search is round-robin after it.
- R10: When no response is taken, no trap context is ready, and the running context is ready, the running context is kept.
- R11: When no context is ready and no response is taken, `idle_o` goes high and the running context number is held. While idle, `mem_block_i` is ignored. A later taken response ends idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_block_i | input | 1 | Memory operation of the running context cannot finish this cycle |
| bus_claim_i | input | 1 | Processor claims the shared context bus this cycle |
| rsp_valid_i | input | 1 | Memory system response strobe |
| rsp_ctx_i | input | CTX_W | Context number carried with the response |
| trap_act_i | input | N_CTX | One bit per context: context is running a trap handler |
| run_ctx_o | output | CTX_W | Context that owns the pipeline this cycle |
| idle_o | output | 1 | No context is ready; pipeline held |
| advance_o | output | 1 | Running context's pipeline moves forward this cycle |
| rsp_take_o | output | 1 | Response accepted this cycle |
| waiting_o | output | N_CTX | Waiting flag of each context |

## Verification
The properties assume that inputs settle before each rising edge and that `rsp_ctx_i` names a loaded context. With the default power-of-two count of four, every encodable number is loaded. They also assume that `trap_act_i` is the trap state for the cycle it is sampled in, and nothing about how it evolves. The stimulus changes every input half a period away from the rising edge and draws response numbers only from the loaded range. It mixes directed sequences with a random phase in which blocks, claims, responses and trap bits collide freely, including responses aimed at contexts that are not waiting.

// File: rtl/ctxs_pkg.sv
package ctxs_pkg;

    // Which rule produced the next running context
    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_RSP  = 2'd1,
        SEL_TRAP = 2'd2,
        SEL_RDY  = 2'd3
    } sel_src_e;

    // Next-state bundle of the scheduler
    typedef struct packed {
        sel_src_e src;
        logic     idle;
    } sched_dec_t;

    function automatic logic is_idle_src(input sel_src_e s);
        return s == SEL_HOLD;
    endfunction

endpackage

// File: rtl/ctx_bus_gate.sv
module ctx_bus_gate #(
    parameter int N_CTX = 4,
    parameter int CTX_W = 2
) (
    input  logic             bus_claim_i,
    input  logic             rsp_valid_i,
    input  logic [CTX_W-1:0] rsp_ctx_i,
    output logic             take_o,
    output logic [N_CTX-1:0] clr_vec_o
);
    // The processor owns the bus whenever it claims it
    assign take_o = rsp_valid_i & ~bus_claim_i;

    for (genvar i = 0; i < N_CTX; i++) begin : g_dec
        assign clr_vec_o[i] = take_o && (rsp_ctx_i == CTX_W'(i));
    end
endmodule

// File: rtl/ctx_wait_flags.sv
module ctx_wait_flags #(
    parameter int N_CTX = 4,
    parameter int CTX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en_i,
    input  logic [CTX_W-1:0] set_idx_i,
    input  logic [N_CTX-1:0] clr_vec_i,
    output logic [N_CTX-1:0] wait_q_o,
    output logic [N_CTX-1:0] wait_nxt_o
);
    for (genvar i = 0; i < N_CTX; i++) begin : g_flag
        logic set_hit;
        assign set_hit = set_en_i && (set_idx_i == CTX_W'(i));

        // A completion clears the flag even if a block sets it in the same cycle
        always_comb begin
            if (clr_vec_i[i])
                wait_nxt_o[i] = 1'b0;
            else if (set_hit)
                wait_nxt_o[i] = 1'b1;
            else
                wait_nxt_o[i] = wait_q_o[i];
        end

        always_ff @(posedge clk) begin
            if (rst)
                wait_q_o[i] <= 1'b0;
            else
                wait_q_o[i] <= wait_nxt_o[i];
        end
    end
endmodule

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
    parameter int N_CTX = 4,
    parameter int CTX_W = 2
) (
    input  logic [N_CTX-1:0] mask_i,
    input  logic [CTX_W-1:0] base_i,
    output logic             found_o,
    output logic [CTX_W-1:0] idx_o
);
    // Scan from base upward with wrap; offset 0 is checked last so it wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = N_CTX - 1; k >= 0; k--) begin
            logic [CTX_W-1:0] pos;
            pos = CTX_W'((int'(base_i) + k) % N_CTX);
            if (mask_i[pos]) begin
                found_o = 1'b1;
                idx_o   = pos;
            end
        end
    end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
    import ctxs_pkg::*;
#(
    parameter int N_CTX = 4,
    parameter int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_block_i,
    input  logic             bus_claim_i,
    input  logic             rsp_valid_i,
    input  logic [CTX_W-1:0] rsp_ctx_i,
    input  logic [N_CTX-1:0] trap_act_i,
    output logic [CTX_W-1:0] run_ctx_o,
    output logic             idle_o,
    output logic             advance_o,
    output logic             rsp_take_o,
    output logic [N_CTX-1:0] waiting_o
);
    logic [CTX_W-1:0] cur_q;
    logic             idle_q;
    logic [N_CTX-1:0] clr_vec;
    logic [N_CTX-1:0] wait_q;
    logic [N_CTX-1:0] wait_nxt;
    logic [N_CTX-1:0] ready_nxt;
    logic [N_CTX-1:0] trap_ready;
    logic             take;
    logic             blk_set;
    logic             trap_found;
    logic [CTX_W-1:0] trap_idx;
    logic             rdy_found;
    logic [CTX_W-1:0] rdy_idx;
    sched_dec_t       dec;

    // A held (idle) pipeline cannot raise a new block
    assign blk_set = mem_block_i & ~idle_q;

    ctx_bus_gate #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_gate (
        .bus_claim_i (bus_claim_i),
        .rsp_valid_i (rsp_valid_i),
        .rsp_ctx_i   (rsp_ctx_i),
        .take_o      (take),
        .clr_vec_o   (clr_vec)
    );

    ctx_wait_flags #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .set_en_i   (blk_set),
        .set_idx_i  (cur_q),
        .clr_vec_i  (clr_vec),
        .wait_q_o   (wait_q),
        .wait_nxt_o (wait_nxt)
    );

    assign ready_nxt  = ~wait_nxt;
    assign trap_ready = ready_nxt & trap_act_i;

    ctx_rr_pick #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_pick_trap (
        .mask_i  (trap_ready),
        .base_i  (cur_q),
        .found_o (trap_found),
        .idx_o   (trap_idx)
    );

    ctx_rr_pick #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_pick_rdy (
        .mask_i  (ready_nxt),
        .base_i  (cur_q),
        .found_o (rdy_found),
        .idx_o   (rdy_idx)
    );

    // Priority: completion, then trap handler, then any ready context
    always_comb begin
        if (take)
            dec.src = SEL_RSP;
        else if (trap_found)
            dec.src = SEL_TRAP;
        else if (rdy_found)
            dec.src = SEL_RDY;
        else
            dec.src = SEL_HOLD;
        dec.idle = is_idle_src(dec.src);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            idle_q <= 1'b0;
        end else begin
            idle_q <= dec.idle;
            case (dec.src)
                SEL_RSP:  cur_q <= rsp_ctx_i;
                SEL_TRAP: cur_q <= trap_idx;
                SEL_RDY:  cur_q <= rdy_idx;
                default:  cur_q <= cur_q;
            endcase
        end
    end

    assign run_ctx_o  = cur_q;
    assign idle_o     = idle_q;
    assign advance_o  = ~idle_q & ~mem_block_i;
    assign rsp_take_o = take;
    assign waiting_o  = wait_q;
endmodule

// File: rtl/ctx_sched_chk.sv
module ctx_sched_chk #(
    parameter int N_CTX = 4,
    parameter int CTX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_block_i,
    input logic             bus_claim_i,
    input logic             rsp_valid_i,
    input logic [CTX_W-1:0] rsp_ctx_i,
    input logic [N_CTX-1:0] trap_act_i,
    input logic [CTX_W-1:0] run_ctx_o,
    input logic             idle_o,
    input logic             advance_o,
    input logic             rsp_take_o,
    input logic [N_CTX-1:0] waiting_o
);
    logic [N_CTX-1:0] trap_d;
    logic [N_CTX-1:0] blk_vec;
    logic [N_CTX-1:0] trap_rdy;

    always_ff @(posedge clk) begin
        if (rst) trap_d <= '0;
        else     trap_d <= trap_act_i;
    end

    for (genvar i = 0; i < N_CTX; i++) begin : g_blk
        assign blk_vec[i] = mem_block_i && !idle_o && (run_ctx_o == CTX_W'(i));
    end
    assign trap_rdy = trap_act_i & ~waiting_o & ~blk_vec;

    assert_wait_not_run_R7: assert property (@(posedge clk) disable iff (rst)
        !idle_o |-> !waiting_o[run_ctx_o]);

    assert_block_stall_R2: assert property (@(posedge clk) disable iff (rst)
        mem_block_i |-> !advance_o);

    assert_block_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_block_i && !idle_o && !(rsp_take_o && rsp_ctx_i == run_ctx_o))
        |=> waiting_o[$past(run_ctx_o)]);

    assert_run_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (!idle_o && !mem_block_i) |-> advance_o);

    assert_claim_R5: assert property (@(posedge clk) disable iff (rst)
        bus_claim_i |-> !rsp_take_o);

    assert_claimed_noeffect_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_i && bus_claim_i && !mem_block_i) |=> $stable(waiting_o));

    assert_rsp_resume_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_take_o |=> (run_ctx_o == $past(rsp_ctx_i)) && !idle_o
                       && !waiting_o[$past(rsp_ctx_i)]);

    assert_trap_first_R9: assert property (@(posedge clk) disable iff (rst)
        (!rsp_take_o && (|trap_rdy)) |=> trap_d[run_ctx_o]);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (idle_o && !rsp_take_o) |=> idle_o && $stable(run_ctx_o));

    assert_idle_all_wait_R11: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> (&waiting_o));
endmodule

bind ctx_sched ctx_sched_chk #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_block_i (mem_block_i),
    .bus_claim_i (bus_claim_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ctx_i   (rsp_ctx_i),
    .trap_act_i  (trap_act_i),
    .run_ctx_o   (run_ctx_o),
    .idle_o      (idle_o),
    .advance_o   (advance_o),
    .rsp_take_o  (rsp_take_o),
    .waiting_o   (waiting_o)
);

// File: tb/ctx_sched_tb.sv
`timescale 1ns/1ps
module ctx_sched_tb;
    localparam int N  = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_block_i = 1'b0;
    logic          bus_claim_i = 1'b0;
    logic          rsp_valid_i = 1'b0;
    logic [CW-1:0] rsp_ctx_i = '0;
    logic [N-1:0]  trap_act_i = '0;
    logic [CW-1:0] run_ctx_o;
    logic          idle_o;
    logic          advance_o;
    logic          rsp_take_o;
    logic [N-1:0]  waiting_o;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    int m_cur  = 0;
    int m_idle = 0;
    bit m_wt [N];

    always #2 clk = ~clk;

    ctx_sched #(.N_CTX(N)) u_dut (
        .clk(clk), .rst(rst), .mem_block_i(mem_block_i), .bus_claim_i(bus_claim_i),
        .rsp_valid_i(rsp_valid_i), .rsp_ctx_i(rsp_ctx_i), .trap_act_i(trap_act_i),
        .run_ctx_o(run_ctx_o), .idle_o(idle_o), .advance_o(advance_o),
        .rsp_take_o(rsp_take_o), .waiting_o(waiting_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int model_wait();
        int v = 0;
        for (int i = 0; i < N; i++) if (m_wt[i]) v |= (1 << i);
        return v;
    endfunction

    task automatic chk_state(input string tag);
        chk(tag, "run_ctx", int'(run_ctx_o), m_cur);
        chk(tag, "idle", int'(idle_o), m_idle);
        chk(tag, "waiting", int'(waiting_o), model_wait());
    endtask

    // One cycle: drive after falling edge, check combinational outputs,
    // advance the model, check registered outputs after the next falling edge.
    task automatic step(input string tag, input bit blk, input bit clm,
                        input bit rv, input int rc, input logic [N-1:0] tr);
        bit take;
        bit nw [N];
        bit found;
        int ncur;
        mem_block_i = blk;
        bus_claim_i = clm;
        rsp_valid_i = rv;
        rsp_ctx_i   = CW'(rc);
        trap_act_i  = tr;
        #0.5;
        take = rv && !clm;
        chk(tag, "advance", int'(advance_o), (m_idle == 0 && !blk) ? 1 : 0);
        chk(tag, "rsp_take", int'(rsp_take_o), take ? 1 : 0);
        for (int i = 0; i < N; i++) nw[i] = m_wt[i];
        if (blk && m_idle == 0) nw[m_cur] = 1'b1;
        if (take) nw[rc] = 1'b0;
        found = 1'b0;
        ncur  = m_cur;
        if (take) begin
            found = 1'b1;
            ncur  = rc;
        end
        for (int k = 0; k < N; k++) begin
            int p = (m_cur + k) % N;
            if (!found && tr[p] && !nw[p]) begin found = 1'b1; ncur = p; end
        end
        for (int k = 0; k < N; k++) begin
            int p = (m_cur + k) % N;
            if (!found && !nw[p]) begin found = 1'b1; ncur = p; end
        end
        for (int i = 0; i < N; i++) m_wt[i] = nw[i];
        m_cur  = ncur;
        m_idle = found ? 0 : 1;
        @(negedge clk);
        #0.5;
        chk_state(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_wt[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        chk_state("R1");

        step("R3",  0, 0, 0, 0, 4'b0000);   // run ctx0, advance
        step("R2",  1, 0, 0, 0, 4'b0000);   // ctx0 blocks -> ctx1
        step("R4",  1, 0, 0, 0, 4'b0000);   // ctx1 blocks -> ctx2
        step("R10", 0, 0, 0, 0, 4'b0000);   // ctx2 keeps running
        step("R5",  0, 1, 1, 0, 4'b0000);   // response during claim ignored
        step("R6",  0, 0, 1, 0, 4'b0000);   // ctx0 resumes
        step("R6",  1, 0, 1, 0, 4'b0000);   // block and response on ctx0: response wins
        step("R6",  0, 0, 1, 3, 4'b0000);   // response to a non-waiting context
        step("R4",  1, 0, 0, 0, 4'b0000);   // ctx3 blocks -> wraps to ctx0
        step("R4",  1, 0, 0, 0, 4'b0000);   // ctx0 blocks -> ctx2
        step("R11", 1, 0, 0, 0, 4'b0000);   // last ready blocks -> idle
        step("R11", 1, 0, 0, 0, 4'b0000);   // block ignored while idle
        step("R11", 0, 1, 1, 2, 4'b0000);   // claimed response, still idle
        step("R8",  0, 0, 1, 3, 4'b0000);   // back-to-back responses
        step("R8",  0, 0, 1, 1, 4'b0000);
        step("R8",  0, 0, 1, 0, 4'b0000);
        step("R9",  0, 0, 0, 0, 4'b1000);   // trap ctx3 ready -> preempts
        step("R9",  0, 0, 0, 0, 4'b1010);   // current trap ctx kept
        step("R9",  1, 0, 0, 0, 4'b1010);   // trap ctx blocks -> other trap ctx
        step("R7",  0, 0, 0, 0, 4'b0000);

        for (int c = 0; c < 600; c++) begin
            bit b  = ($urandom_range(0, 99) < 35);
            bit cl = ($urandom_range(0, 99) < 30);
            bit rv = ($urandom_range(0, 99) < 30);
            int rc = $urandom_range(0, N - 1);
            logic [N-1:0] tr = ($urandom_range(0, 99) < 20) ? N'($urandom_range(0, 15)) : '0;
            step("R7", b, cl, rv, rc, tr);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule